// File: doc/BRIEF.md
# Power-On Reset Time-Out Sequencer

This block keeps a processor core in reset after power-on until its clocks can be trusted. It runs up to three timed waits in a fixed order: first a power-up delay counted on a slow internal RC timebase, then an oscillator start-up delay counted on the external oscillator, and last a PLL lock delay counted on the internal timebase again. The oscillator mode code and an active-low power-up-timer enable decide which of the three waits take place. Any wait that does not apply costs one control clock and nothing more.

All waits start from the power-on reset pulse. The external active-low reset pin does not affect them. If the pin is held low until the sequence is complete, releasing it lets the core run on the next clock edge. Each timebase arrives as a slow square-wave tick. The block synchronizes each tick into the control clock and counts one step for every rising transition. A new power-on pulse restarts the whole sequence and clears every counter. All counts are parameters, so a bench can use short values.

Top module: `por_seq_top`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 after the next clock edge. A power-on pulse returns the sequence to its start and clears every stage count, so a restarted stage needs its full tick count again.
- R2: The power-up stage runs only when `pwrt_en_n_i` is 0. It holds the core in reset until `PWRT_TICKS` internal ticks have been counted, and after `PWRT_TICKS-1` ticks the core is still in reset.
- R3: The oscillator stage runs only in crystal modes (`osc_mode_i` 0 = LP, 1 = XT, 2 = HS, 3 = HS with PLL). It counts `OST_TICKS` oscillator ticks and begins only after the power-up stage ends. Oscillator ticks that arrive during the power-up stage are not counted.
- R4: The PLL stage runs only in mode 3. It follows the oscillator stage and lasts `PLL_TICKS` internal ticks. Modes 4 to 7 (4 and 5 external clock, 6 RC, 7 internal oscillator) skip both the oscillator stage and the PLL stage.
- R5: A stage that does not apply takes exactly one control clock. With `pwrt_en_n_i` = 1 in a mode from 4 to 7, `core_rst_o` is still 1 three clock edges after `por_i` falls and is 0 after the fourth edge.
- R6: `core_rst_o` is 1 on the clock edge after any cycle in which `ext_rst_n_i` is 0, and the stages keep counting while the pin is low. When the pin goes high after the sequence is complete, `core_rst_o` is 0 after the next edge. `core_rst_o` falls only when the sequence is complete.
- R7: Each tick input passes through a two-flop synchronizer. Each low-to-high transition counts once, however many control clocks the tick stays high.
- R8: The sequencer state is one-hot across five states: start, power-up, oscillator, PLL and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_i | input | 1 | Power-on reset pulse, active high, synchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| pwrt_en_n_i | input | 1 | Power-up timer enable, 0 = enabled |
| osc_mode_i | input | 3 | Oscillator mode code (see R3, R4) |
| intrc_tick_i | input | 1 | Internal RC timebase tick, asynchronous square wave |
| osc_tick_i | input | 1 | External oscillator tick, asynchronous square wave |
| core_rst_o | output | 1 | Core reset, active high, registered |

## Verification
The bench sweeps all eight mode codes against both settings of the power-up enable. For each pairing it feeds every applicable stage one tick short of its limit and then the final tick. This separates a wrong stage order, a miscounted limit and a stage that runs when it should not. Oscillator ticks are sent during the power-up wait so that early counting shows up as an early release. The bench also runs a long-held tick, a restart in the middle of the oscillator wait, and the release of the external pin after a completed sequence. Each of these exposes one specific fault: edge-detection errors, counters that are not cleared, and gating of the external pin.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  localparam int NST    = 5;
  localparam int S_POR  = 0;
  localparam int S_PWRT = 1;
  localparam int S_OST  = 2;
  localparam int S_PLL  = 3;
  localparam int S_DONE = 4;

  localparam logic [2:0] MODE_HSPLL = 3'd3;

  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode <= 3'd3);
  endfunction

  function automatic logic is_pll(input logic [2:0] mode);
    return (mode == MODE_HSPLL);
  endfunction
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/stage_cnt.sv
module stage_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic step,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (clr) cnt_q <= '0;
    else if (en && step && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import por_seq_pkg::*;
(
  input  logic           clk,
  input  logic           por,
  input  logic           pwrt_en_n,
  input  logic [2:0]     mode,
  input  logic [2:0]     done,
  output logic [NST-1:0] state_q,
  output logic [NST-1:0] state_d
);
  always_comb begin
    state_d = '0;
    unique case (1'b1)
      state_q[S_POR]:  state_d[S_PWRT] = 1'b1;
      state_q[S_PWRT]: if (pwrt_en_n || done[0]) state_d[S_OST] = 1'b1;
                       else state_d[S_PWRT] = 1'b1;
      state_q[S_OST]:  if (!is_crystal(mode) || done[1]) state_d[S_PLL] = 1'b1;
                       else state_d[S_OST] = 1'b1;
      state_q[S_PLL]:  if (!is_pll(mode) || done[2]) state_d[S_DONE] = 1'b1;
                       else state_d[S_PLL] = 1'b1;
      default:         state_d[S_DONE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) state_q <= NST'(1) << S_POR;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/por_seq_top.sv
module por_seq_top
  import por_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_TICKS  = 1024,
  parameter int PLL_TICKS  = 63,
  parameter int SYNC_FF    = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       ext_rst_n_i,
  input  logic       pwrt_en_n_i,
  input  logic [2:0] osc_mode_i,
  input  logic       intrc_tick_i,
  input  logic       osc_tick_i,
  output logic       core_rst_o
);
  localparam int NTB = 2;

  logic [NTB-1:0] tick_raw;
  logic [NTB-1:0] tick_pls;
  logic [2:0]     stage_done;
  logic [NST-1:0] state_q;
  logic [NST-1:0] state_d;
  logic           core_rst_q;

  assign tick_raw = {osc_tick_i, intrc_tick_i};

  for (genvar g = 0; g < NTB; g++) begin : g_sync
    tick_sync #(.STAGES(SYNC_FF)) u_sync (
      .clk    (clk),
      .rst    (por_i),
      .tick_i (tick_raw[g]),
      .pulse_o(tick_pls[g])
    );
  end

  stage_cnt #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk(clk), .clr(por_i), .en(state_q[S_PWRT]),
    .step(tick_pls[0]), .done_o(stage_done[0])
  );

  stage_cnt #(.LIMIT(OST_TICKS)) u_ost_cnt (
    .clk(clk), .clr(por_i), .en(state_q[S_OST]),
    .step(tick_pls[1]), .done_o(stage_done[1])
  );

  stage_cnt #(.LIMIT(PLL_TICKS)) u_pll_cnt (
    .clk(clk), .clr(por_i), .en(state_q[S_PLL]),
    .step(tick_pls[0]), .done_o(stage_done[2])
  );

  seq_fsm u_fsm (
    .clk      (clk),
    .por      (por_i),
    .pwrt_en_n(pwrt_en_n_i),
    .mode     (osc_mode_i),
    .done     (stage_done),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  always_ff @(posedge clk) begin
    if (por_i) core_rst_q <= 1'b1;
    else       core_rst_q <= !state_d[S_DONE] || !ext_rst_n_i;
  end

  assign core_rst_o = core_rst_q;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk
  import por_seq_pkg::*;
(
  input logic           clk,
  input logic           por_i,
  input logic           ext_rst_n_i,
  input logic           pwrt_en_n_i,
  input logic [2:0]     osc_mode_i,
  input logic           core_rst_o,
  input logic [NST-1:0] state_q,
  input logic [2:0]     stage_done
);
  AST_POR_HOLDS_RST: assert property (@(posedge clk)
    por_i |=> core_rst_o); // R1

  AST_PWRT_WAITS: assert property (@(posedge clk) disable iff (por_i)
    (state_q[S_PWRT] && !pwrt_en_n_i && !stage_done[0]) |=> state_q[S_PWRT]); // R2

  AST_OST_WAITS: assert property (@(posedge clk) disable iff (por_i)
    (state_q[S_OST] && is_crystal(osc_mode_i) && !stage_done[1]) |=> state_q[S_OST]); // R3

  AST_PLL_WAITS: assert property (@(posedge clk) disable iff (por_i)
    (state_q[S_PLL] && is_pll(osc_mode_i) && !stage_done[2]) |=> state_q[S_PLL]); // R4

  AST_SKIP_ONE_CLK: assert property (@(posedge clk) disable iff (por_i)
    (state_q[S_PWRT] && pwrt_en_n_i) |=> state_q[S_OST]); // R5

  AST_PIN_HOLDS_RST: assert property (@(posedge clk) disable iff (por_i)
    !ext_rst_n_i |=> core_rst_o); // R6

  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> state_q[S_DONE]); // R6

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (por_i)
    $countones(state_q) == 1); // R8
endmodule

bind por_seq_top por_seq_chk u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .ext_rst_n_i(ext_rst_n_i),
  .pwrt_en_n_i(pwrt_en_n_i),
  .osc_mode_i (osc_mode_i),
  .core_rst_o (core_rst_o),
  .state_q    (state_q),
  .stage_done (stage_done)
);

// File: tb/tb_por_seq_top.sv
module tb_por_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW_T  = 6;
  localparam int OS_T  = 5;
  localparam int PL_T  = 4;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ext_n = 1'b1;
  logic       pwrt_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       itick = 1'b0;
  logic       otick = 1'b0;
  logic       core_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  por_seq_top #(.PWRT_TICKS(PW_T), .OST_TICKS(OS_T), .PLL_TICKS(PL_T)) dut (
    .clk(clk), .por_i(por), .ext_rst_n_i(ext_n), .pwrt_en_n_i(pwrt_n),
    .osc_mode_i(mode), .intrc_tick_i(itick), .osc_tick_i(otick),
    .core_rst_o(core_rst)
  );

  task automatic chk(input logic exp, input string req, input string what);
    n_chk++;
    if (core_rst !== exp) begin
      n_fail++;
      $display("FAIL %s %s: core_rst actual=%b expected=%b (mode=%0d pwrt_n=%b)",
               req, what, core_rst, exp, mode, pwrt_n);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk); por = 1'b1;
    cyc(2);
    por = 1'b0;
  endtask

  task automatic ipulse(input int n, input int hold = 3);
    for (int i = 0; i < n; i++) begin
      itick = 1'b1; cyc(hold);
      itick = 1'b0; cyc(3);
    end
  endtask

  task automatic opulse(input int n);
    for (int i = 0; i < n; i++) begin
      otick = 1'b1; cyc(3);
      otick = 1'b0; cyc(3);
    end
  endtask

  // full sequence for one mode / enable pairing, checking each stage boundary
  task automatic run_cfg(input logic [2:0] m, input logic dis);
    logic pw, os, pl;
    mode = m; pwrt_n = dis;
    pw = !dis; os = (m <= 3'd3); pl = (m == 3'd3);
    do_por();
    chk(1'b1, "R1", "right after por");
    cyc(8);
    chk(pw | os | pl, "R5", "after skipping stages");
    if (pw) begin
      opulse(OS_T);              // must be ignored during power-up stage
      ipulse(PW_T - 1); cyc(6);
      chk(1'b1, "R2", "one tick short of power-up limit");
      ipulse(1); cyc(6);
      chk(os | pl, "R2", "power-up limit reached");
    end
    if (os) begin
      opulse(OS_T - 1); cyc(6);
      chk(1'b1, "R3", "one tick short of oscillator limit");
      opulse(1); cyc(6);
      chk(pl, "R3", "oscillator limit reached");
    end
    if (pl) begin
      ipulse(PL_T - 1); cyc(6);
      chk(1'b1, "R4", "one tick short of PLL limit");
      ipulse(1); cyc(6);
      chk(1'b0, "R4", "PLL limit reached");
    end
  endtask

  initial begin
    cyc(3);
    chk(1'b1, "R1", "reset state");
    por = 1'b0;

    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 2; d++)
        run_cfg(3'(m), d[0]);

    // R5: exact edge count with every stage skipped
    for (int m = 4; m < 8; m++) begin
      mode = 3'(m); pwrt_n = 1'b1;
      @(negedge clk); por = 1'b1; cyc(2); por = 1'b0;
      cyc(3);
      chk(1'b1, "R5", "three edges after por falls");
      cyc(1);
      chk(1'b0, "R5", "fourth edge after por falls");
    end

    // R7: a long-held tick counts once
    mode = 3'd7; pwrt_n = 1'b0;
    do_por();
    ipulse(1, 25);
    ipulse(PW_T - 2); cyc(6);
    chk(1'b1, "R7", "long tick counted once");
    ipulse(1); cyc(6);
    chk(1'b0, "R7", "final tick after long tick");

    // R6: pin held low through the whole sequence
    mode = 3'd3; pwrt_n = 1'b0;
    ext_n = 1'b0;
    do_por();
    ipulse(PW_T); opulse(OS_T); ipulse(PL_T); cyc(6);
    chk(1'b1, "R6", "pin low after sequence done");
    ext_n = 1'b1; cyc(1);
    chk(1'b0, "R6", "release one edge after pin high");
    ext_n = 1'b0; cyc(1);
    chk(1'b1, "R6", "pin low again reasserts");
    ext_n = 1'b1; cyc(1);
    chk(1'b0, "R6", "pin high again releases");

    // R1: restart in the middle of the oscillator stage clears counters
    mode = 3'd2; pwrt_n = 1'b0;
    do_por();
    ipulse(PW_T); opulse(2);
    do_por();
    chk(1'b1, "R1", "restart asserts reset");
    ipulse(PW_T - 1); cyc(6);
    chk(1'b1, "R1", "power-up count cleared by restart");
    ipulse(1); opulse(OS_T - 1); cyc(6);
    chk(1'b1, "R1", "oscillator count cleared by restart");
    opulse(1); cyc(6);
    chk(1'b0, "R1", "restarted sequence completes");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule